// File: doc/BRIEF.md
# Embedded PPS clock decoder

The decoder takes a 10 MHz carrier whose duty cycle flags the second boundary. Once per second one carrier period is high for a quarter of the period and low for the rest. Every other period is a plain square wave. The carrier is sampled by an oversampling clock at eight times the carrier rate and passed through a flip-flop synchronizer. From the synchronized level the decoder measures two things: the high time of each period and the time from one rising edge to the next. Each period is then classed as normal, marker or invalid.

There are three outputs. A one-tick `pps_o` pulse flags the second boundary and carries a tick-count timestamp of the marker's rising edge, with the synchronizer delay taken out. A lock flag tracks whether markers arrive at the configured spacing. A saturating counter counts malformed periods. A chip-level timing block uses these to discipline its local time base from a single clock wire, with no separate PPS line.

Top module: `epps_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pps_o`, `period_strobe_o` and `lock_o` are 0 and `err_cnt_o` is 0.
- R2: A period is measured in ticks from one synchronized rising edge to the next. It is normal when the period is 7 to 9 ticks and the high time is 3 to 5 ticks. It is a marker when the period is 7 to 9 ticks and the high time is 1 to 2 ticks. Anything else is invalid. `period_strobe_o` pulses for one tick for each completed normal or marker period and never for an invalid one.
- R3: If no rising edge follows within 9 ticks of the previous one, that period is classed invalid once. Measurement then restarts at the next rising edge.
- R4: For a period whose high time h is 1 or 2 ticks, `pps_o` is high for exactly one tick, h+2 ticks after the tick given in `pps_stamp_o`.
- R5: The tick counter is 0 in reset and advances by 1 on every clock edge after reset is released. `pps_stamp_o` equals the counter value just after the first sampling edge that captured the marker's high level.
- R6: `lock_o` rises when a marker completes exactly MARKER_GAP periods after the previous marker, with only normal periods in between.
- R7: An invalid period clears `lock_o`.
- R8: `lock_o` clears when the MARKER_GAP-th period after a marker is normal, or when a marker arrives earlier than that.
- R9: `err_cnt_o` adds 1 for each invalid period and holds at 2^ERR_W-1.
- R10: `err_clr_i` zeroes `err_cnt_o` on the next tick and takes priority over a simultaneous increment.
- R11: The first rising edge after reset or after a timeout only starts measurement. It produces no classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 8x the carrier rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_i | input | 1 | Asynchronous 10 MHz carrier with duty-cycle marker |
| err_clr_i | input | 1 | Clears the invalid-period counter |
| pps_o | output | 1 | One-tick second-boundary pulse |
| pps_stamp_o | output | TS_W | Tick count of the marker's rising edge |
| period_strobe_o | output | 1 | One tick per valid carrier period |
| lock_o | output | 1 | Markers arriving at the configured spacing |
| err_cnt_o | output | ERR_W | Saturating invalid-period count |

## Verification
The classifier is swept over every high time from 1 tick up to one below the period, for periods of 6 to 10 ticks. This covers normal, marker, short, long and timed-out periods. Each case separates high-time decoding from period-length decoding, and the timeout path from the late-edge path. Marker streams with correct spacing, a skipped marker, an early marker and a malformed period are used to tell the lock conditions apart. A long run of short periods drives the error counter into saturation and is then cleared.

// File: rtl/epps_pkg.sv
package epps_pkg;
  typedef enum logic [1:0] {
    PC_NORMAL  = 2'd0,
    PC_MARKER  = 2'd1,
    PC_INVALID = 2'd2
  } per_class_e;
endpackage

// File: rtl/epps_sync.sv
module epps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = q_o & ~last_q;
  assign fall_o = ~q_o & last_q;
endmodule

// File: rtl/epps_meas.sv
module epps_meas
  import epps_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int TS_W        = 32,
  parameter int SYNC_LAT    = 1,
  parameter int MARK_HI_MIN = 1,
  parameter int MARK_HI_MAX = 2,
  parameter int NORM_HI_MIN = 3,
  parameter int NORM_HI_MAX = 5,
  parameter int PER_MIN     = 7,
  parameter int PER_MAX     = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            level_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic [TS_W-1:0] tick_i,
  output logic            done_o,
  output per_class_e      class_o,
  output logic            mark_o,
  output logic [TS_W-1:0] stamp_o
);
  localparam logic [CNT_W-1:0] M_LO = CNT_W'(MARK_HI_MIN);
  localparam logic [CNT_W-1:0] M_HI = CNT_W'(MARK_HI_MAX);
  localparam logic [CNT_W-1:0] N_LO = CNT_W'(NORM_HI_MIN);
  localparam logic [CNT_W-1:0] N_HI = CNT_W'(NORM_HI_MAX);
  localparam logic [CNT_W-1:0] P_LO = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] P_HI = CNT_W'(PER_MAX);
  localparam logic [TS_W-1:0]  LAT  = TS_W'(SYNC_LAT);

  logic             seen_q;
  logic [CNT_W-1:0] per_cnt_q, hi_cnt_q, hi_len_q;
  logic             hi_ok_q;
  logic [TS_W-1:0]  rise_ts_q;
  logic             hi_is_mark;

  assign hi_is_mark = (hi_cnt_q >= M_LO) && (hi_cnt_q <= M_HI);

  function automatic per_class_e classify(input logic [CNT_W-1:0] per,
                                          input logic [CNT_W-1:0] hi,
                                          input logic ok);
    if (!ok || per < P_LO || per > P_HI) return PC_INVALID;
    if (hi >= M_LO && hi <= M_HI)        return PC_MARKER;
    if (hi >= N_LO && hi <= N_HI)        return PC_NORMAL;
    return PC_INVALID;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q    <= 1'b0;
      per_cnt_q <= '0;
      hi_cnt_q  <= '0;
      hi_len_q  <= '0;
      hi_ok_q   <= 1'b0;
      rise_ts_q <= '0;
      done_o    <= 1'b0;
      class_o   <= PC_NORMAL;
      mark_o    <= 1'b0;
      stamp_o   <= '0;
    end else begin
      done_o <= 1'b0;
      mark_o <= 1'b0;
      if (rise_i) begin
        if (seen_q) begin
          done_o  <= 1'b1;
          class_o <= classify(per_cnt_q, hi_len_q, hi_ok_q);
        end
        seen_q    <= 1'b1;
        per_cnt_q <= CNT_W'(1);
        hi_cnt_q  <= CNT_W'(1);
        hi_ok_q   <= 1'b0;
        rise_ts_q <= tick_i - LAT;
      end else if (seen_q) begin
        if (per_cnt_q == P_HI) begin
          // no edge in time: period is over-long
          done_o  <= 1'b1;
          class_o <= PC_INVALID;
          seen_q  <= 1'b0;
        end else begin
          per_cnt_q <= per_cnt_q + 1'b1;
        end
        if (level_i && hi_cnt_q != '1) hi_cnt_q <= hi_cnt_q + 1'b1;
        if (fall_i) begin
          hi_len_q <= hi_cnt_q;
          hi_ok_q  <= 1'b1;
          if (hi_is_mark) begin
            mark_o  <= 1'b1;
            stamp_o <= rise_ts_q;
          end
        end
      end
    end
  end

  a_r4_pps_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |=> !mark_o);
  a_r2_done_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_period_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (per_cnt_q <= P_HI));
  a_r4_mark_not_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mark_o && done_o));
endmodule

// File: rtl/epps_lock.sv
module epps_lock
  import epps_pkg::*;
#(
  parameter int MARKER_GAP = 10_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  per_class_e class_i,
  output logic       lock_o
);
  localparam int GAP_W = (MARKER_GAP > 2) ? $clog2(MARKER_GAP) : 1;
  localparam logic [GAP_W-1:0] LAST = GAP_W'(MARKER_GAP - 1);

  logic             have_q;
  logic [GAP_W-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o  <= 1'b0;
      have_q  <= 1'b0;
      since_q <= '0;
    end else if (done_i) begin
      unique case (class_i)
        PC_MARKER: begin
          lock_o  <= have_q && (since_q == LAST);
          have_q  <= 1'b1;
          since_q <= '0;
        end
        PC_NORMAL: begin
          if (have_q) begin
            if (since_q == LAST) begin
              // expected marker missing
              lock_o  <= 1'b0;
              have_q  <= 1'b0;
              since_q <= '0;
            end else begin
              since_q <= since_q + 1'b1;
            end
          end
        end
        default: begin
          lock_o  <= 1'b0;
          have_q  <= 1'b0;
          since_q <= '0;
        end
      endcase
    end
  end

  a_r6_lock_on_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(done_i && class_i == PC_MARKER));
  a_r7_drop_on_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && class_i == PC_INVALID) |=> !lock_o);
endmodule

// File: rtl/epps_err_cnt.sv
module epps_err_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end

  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  a_r9_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '1 && !clr_i) |=> (cnt_o == '1));
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/epps_decoder.sv
module epps_decoder
  import epps_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TS_W        = 32,
  parameter int ERR_W       = 8,
  parameter int MARKER_GAP  = 10_000_000,
  parameter int MARK_HI_MIN = 1,
  parameter int MARK_HI_MAX = 2,
  parameter int NORM_HI_MIN = 3,
  parameter int NORM_HI_MAX = 5,
  parameter int PER_MIN     = 7,
  parameter int PER_MAX     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             carrier_i,
  input  logic             err_clr_i,
  output logic             pps_o,
  output logic [TS_W-1:0]  pps_stamp_o,
  output logic             period_strobe_o,
  output logic             lock_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int CNT_W    = $clog2(PER_MAX + 2);
  localparam int SYNC_LAT = SYNC_STAGES - 1;

  logic            lvl, rise, fall;
  logic [TS_W-1:0] tick_q;
  logic            done;
  per_class_e      pclass;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_q + 1'b1;

  epps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(carrier_i),
    .q_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  epps_meas #(
    .CNT_W(CNT_W), .TS_W(TS_W), .SYNC_LAT(SYNC_LAT),
    .MARK_HI_MIN(MARK_HI_MIN), .MARK_HI_MAX(MARK_HI_MAX),
    .NORM_HI_MIN(NORM_HI_MIN), .NORM_HI_MAX(NORM_HI_MAX),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
  ) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(lvl), .rise_i(rise),
    .fall_i(fall), .tick_i(tick_q), .done_o(done), .class_o(pclass),
    .mark_o(pps_o), .stamp_o(pps_stamp_o)
  );

  epps_lock #(.MARKER_GAP(MARKER_GAP)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .class_i(pclass),
    .lock_o(lock_o)
  );

  epps_err_cnt #(.W(ERR_W)) u_err (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(done && pclass == PC_INVALID), .clr_i(err_clr_i),
    .cnt_o(err_cnt_o)
  );

  assign period_strobe_o = done && (pclass != PC_INVALID);

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!pps_o && !lock_o && !period_strobe_o));
endmodule

// File: tb/epps_decoder_tb_top.sv
module epps_decoder_tb_top;
  localparam int TS_W  = 32;
  localparam int ERR_W = 3;
  localparam int GAP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier = 1'b0;
  logic err_clr = 1'b0;
  logic pps, strobe, lock;
  logic [TS_W-1:0]  stamp;
  logic [ERR_W-1:0] err_cnt;

  int checks = 0, errors = 0;
  longint cyc = 0;
  longint exp_stamp = 0, exp_pps_cyc = 0;
  bit win = 1'b0;
  int pps_seen = 0, strobe_seen = 0;

  always #5 clk = ~clk;

  epps_decoder #(
    .TS_W(TS_W), .ERR_W(ERR_W), .MARKER_GAP(GAP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .carrier_i(carrier), .err_clr_i(err_clr),
    .pps_o(pps), .pps_stamp_o(stamp), .period_strobe_o(strobe),
    .lock_o(lock), .err_cnt_o(err_cnt)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pulse monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pps) begin
        if (win) pps_seen++;
        check(longint'(stamp) == exp_stamp, "R5", "pps stamp", longint'(stamp), exp_stamp);
        check(cyc == exp_pps_cyc, "R4", "pps timing", cyc, exp_pps_cyc);
      end
      if (strobe && win) strobe_seen++;
    end
  end

  // called on a falling edge; returns on a falling edge
  task automatic send(int hi, int per);
    carrier = 1'b1;
    if (hi <= 2) begin
      exp_stamp   = cyc + 1;
      exp_pps_cyc = cyc + 1 + hi + 2;
    end
    repeat (hi) @(negedge clk);
    carrier = 1'b0;
    repeat (per - hi) @(negedge clk);
  endtask

  task automatic idle_clear();
    carrier = 1'b0;
    repeat (20) @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_lock(bit exp, string req);
    check(lock == exp, req, "lock", longint'(lock), longint'(exp));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(!pps && !strobe && !lock, "R1", "outputs in reset", {pps, strobe, lock}, 0);
    check(err_cnt == 0, "R1", "err in reset", err_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pps && !strobe && !lock && err_cnt == 0, "R1", "outputs after reset",
          {pps, strobe, lock, err_cnt}, 0);

    // classification sweep
    for (int per = 6; per <= 10; per++) begin
      for (int hi = 1; hi < per; hi++) begin
        bit valid, mark;
        idle_clear();
        valid = (per >= 7 && per <= 9) && (hi <= 5);
        mark  = (hi <= 2);
        pps_seen = 0;
        strobe_seen = 0;
        win = 1'b1;
        send(4, 8);
        send(4, 8);
        send(hi, per);
        send(4, 8);
        win = 1'b0;
        // R11: fresh start gives no strobe, two primes give two
        check(strobe_seen == 2 + int'(valid), valid ? "R2" : ((per > 9) ? "R3" : "R11"),
              $sformatf("strobes hi=%0d per=%0d", hi, per), strobe_seen, 2 + int'(valid));
        check(err_cnt == ERR_W'(!valid), (per > 9) ? "R3" : "R9",
              $sformatf("err hi=%0d per=%0d", hi, per), err_cnt, int'(!valid));
        check(pps_seen == int'(mark), "R4",
              $sformatf("pps count hi=%0d per=%0d", hi, per), pps_seen, int'(mark));
      end
    end

    // lock behaviour
    idle_clear();
    send(2, 8); send(4, 8); send(4, 8); send(4, 8);
    expect_lock(1'b0, "R6");
    send(2, 8); send(4, 8);
    expect_lock(1'b1, "R6");
    send(4, 8); send(4, 8); send(2, 8); send(4, 8);
    expect_lock(1'b1, "R6");
    send(4, 8); send(4, 8); send(4, 8); send(4, 8);
    expect_lock(1'b0, "R8");
    send(2, 8); send(4, 8); send(4, 8); send(4, 8); send(2, 8); send(4, 8);
    expect_lock(1'b1, "R6");
    send(4, 6); send(4, 8);
    expect_lock(1'b0, "R7");
    send(2, 8); send(4, 8); send(4, 8); send(4, 8); send(2, 8); send(4, 8);
    expect_lock(1'b1, "R6");
    send(4, 8); send(2, 8); send(4, 8);
    expect_lock(1'b0, "R8");

    // saturation and clear
    idle_clear();
    for (int i = 0; i < 10; i++) send(4, 6);
    send(4, 8);
    check(err_cnt == 3'd7, "R9", "err saturated", err_cnt, 7);
    expect_lock(1'b0, "R7");
    repeat (20) @(negedge clk);
    check(err_cnt == 3'd7, "R9", "err holds at max", err_cnt, 7);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(err_cnt == 0, "R10", "err cleared", err_cnt, 0);
    @(negedge clk);
    check(err_cnt == 0, "R10", "err stays clear", err_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule